// File: doc/BRIEF.md
# Compare-Value Deadline Timer

A single timer channel that watches a free-running 64-bit system count supplied from outside. Software sets a deadline in one of two ways. It can write an absolute 64-bit compare value. It can also write a signed 32-bit tick offset, which the block adds to the count at the moment of the write. A small control register holds two bits. The enable bit arms the channel. The mask bit silences the interrupt pin without disarming it. A read-only status bit reports that the deadline has been reached.

The interrupt output is a pure level: enabled, unmasked and deadline reached. Nothing is latched, so any write that moves the deadline or disarms the channel acts on the pin in the cycle after that write's clock edge. A change of the count acts at once. Reads are combinational through a four-entry register window: control, absolute compare, relative view, and the count.

Top module: `deadline_timer`

## Requirements
- R1: Reset (active-low rst_ni) clears control and compare to zero and holds irq_o low. While reset is held, control and compare read as zero.
- R2: Control layout: bit 0 enable, bit 1 mask, bit 2 status. A control write stores only bits 1:0. Bit 2 and all higher write bits are ignored, and bits 63:3 read as zero.
- R3: The deadline is met when count_i >= compare, as an unsigned 64-bit comparison. The status bit never reads 1 before that. The status bit reads 0 while enable is 0.
- R4: irq_o is high exactly when enable=1, mask=0 and the deadline is met. It is a level that follows count_i in the same cycle.
- R5: A compare write (address 1) to a value already passed, while enabled and unmasked, raises irq_o right after that write's clock edge.
- R6: Writing 0 to control (address 0) drops irq_o right after the write edge.
- R7: A relative write (address 2) sets compare to count_i, taken at the write edge, plus the sign-extended low 32 bits of the write data.
- R8: A relative read returns the low 32 bits of (compare - count_i), sign-extended to 64 bits. After expiry it reads negative.
- R9: A count read (address 3) returns count_i. Writes to address 3 change neither control nor compare.
- R10: With enable and mask both set, irq_o stays low while the status bit still reports the deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| count_i | input | 64 | Free-running system count |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 control, 1 compare, 2 relative, 3 count |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Combinational read data for addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default 64-bit count and 32-bit relative view. Because the count is an input, the bench places it anywhere in its range. This reaches the unsigned crossing at bit 63 and the truncation of the relative view when the distance to the deadline exceeds 32 bits. It also reaches sign extension of negative offsets and the boundary cycles one tick before and exactly at the deadline.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTL   = 2'd0,
    SEL_CMP   = 2'd1,
    SEL_REL   = 2'd2,
    SEL_COUNT = 2'd3
  } reg_sel_e;

  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_MASK_BIT = 1;
  localparam int unsigned CTL_STAT_BIT = 2;
  localparam int unsigned CTL_RW_W     = 2;
endpackage

// File: rtl/timer_ctl_reg.sv
module timer_ctl_reg
  import timer_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [CTL_RW_W-1:0] wdata_i,
  output logic                enable_o,
  output logic                mask_o
);
  logic [CTL_RW_W-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= wdata_i;
  end

  assign enable_o = ctl_q[CTL_EN_BIT];
  assign mask_o   = ctl_q[CTL_MASK_BIT];
endmodule

// File: rtl/timer_deadline.sv
module timer_deadline #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned REL_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             abs_we_i,
  input  logic             rel_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             met_o,
  output logic [REL_W-1:0] rel_o
);
  localparam int unsigned EXT_W = CNT_W - REL_W;

  logic [CNT_W-1:0] cmp_q, cmp_d, rel_ext, diff;

  // signed offset widened to the count width
  assign rel_ext = {{EXT_W{wdata_i[REL_W-1]}}, wdata_i[REL_W-1:0]};

  always_comb begin
    cmp_d = cmp_q;
    if (abs_we_i)      cmp_d = wdata_i;
    else if (rel_we_i) cmp_d = count_i + rel_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp_q <= '0;
    else         cmp_q <= cmp_d;
  end

  assign diff  = cmp_q - count_i;
  assign rel_o = diff[REL_W-1:0];
  assign met_o = (count_i >= cmp_q);
  assign cmp_o = cmp_q;
endmodule

// File: rtl/timer_rd_mux.sv
module timer_rd_mux
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned REL_W = 32
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             enable_i,
  input  logic             mask_i,
  input  logic             status_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [REL_W-1:0] rel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] rdata_o
);
  localparam int unsigned EXT_W = CNT_W - REL_W;

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_e'(sel_i))
      SEL_CTL: begin
        rdata_o[CTL_EN_BIT]   = enable_i;
        rdata_o[CTL_MASK_BIT] = mask_i;
        rdata_o[CTL_STAT_BIT] = status_i;
      end
      SEL_CMP:   rdata_o = cmp_i;
      SEL_REL:   rdata_o = {{EXT_W{rel_i[REL_W-1]}}, rel_i};
      SEL_COUNT: rdata_o = count_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/deadline_timer.sv
module deadline_timer
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned REL_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  logic             en_w, mask_w, met_w, status_w;
  logic             ctl_we, abs_we, rel_we;
  logic [CNT_W-1:0] cval_w;
  logic [REL_W-1:0] rel_w;

  assign ctl_we = wr_en_i && (addr_i == SEL_CTL);
  assign abs_we = wr_en_i && (addr_i == SEL_CMP);
  assign rel_we = wr_en_i && (addr_i == SEL_REL);

  timer_ctl_reg u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctl_we),
    .wdata_i  (wdata_i[CTL_RW_W-1:0]),
    .enable_o (en_w),
    .mask_o   (mask_w)
  );

  timer_deadline #(.CNT_W(CNT_W), .REL_W(REL_W)) u_dl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .count_i  (count_i),
    .abs_we_i (abs_we),
    .rel_we_i (rel_we),
    .wdata_i  (wdata_i),
    .cmp_o    (cval_w),
    .met_o    (met_w),
    .rel_o    (rel_w)
  );

  assign status_w = en_w & met_w;
  assign irq_o    = status_w & ~mask_w;

  timer_rd_mux #(.CNT_W(CNT_W), .REL_W(REL_W)) u_rd (
    .sel_i    (addr_i),
    .enable_i (en_w),
    .mask_i   (mask_w),
    .status_i (status_w),
    .cmp_i    (cval_w),
    .rel_i    (rel_w),
    .count_i  (count_i),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/deadline_timer_chk.sv
module deadline_timer_chk
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned REL_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_i,
  input logic             wr_en_i,
  input logic [SEL_W-1:0] addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] rdata_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cval_q,
  input logic             en_q,
  input logic             mask_q
);
  localparam int unsigned EXT_W = CNT_W - REL_W;

  // R3: output never high ahead of the deadline
  a_r3_no_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (count_i >= cval_q));

  // R5: absolute write lands verbatim
  a_r5_cmp_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == SEL_CMP) |=> (cval_q == $past(wdata_i)));

  // R6: control cleared silences output
  a_r6_ctl_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == SEL_CTL && wdata_i[1:0] == 2'b00) |=> !irq_o);

  // R7: relative write is count plus sign-extended offset
  a_r7_rel_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == SEL_REL) |=>
      (cval_q == $past(count_i) + {{EXT_W{$past(wdata_i[REL_W-1])}}, $past(wdata_i[REL_W-1:0])}));

  // R9: count window and ignored count writes
  a_r9_count_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == SEL_COUNT) |-> (rdata_o == count_i));
  a_r9_count_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == SEL_COUNT) |=> ($stable(cval_q) && $stable(en_q) && $stable(mask_q)));

  // R10: masked channel stays silent
  a_r10_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q |-> !irq_o);

  // R4: disabled channel stays silent
  a_r4_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !irq_o);
endmodule

bind deadline_timer deadline_timer_chk #(.CNT_W(CNT_W), .REL_W(REL_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .count_i (count_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .cval_q  (cval_w),
  .en_q    (en_w),
  .mask_q  (mask_w)
);

// File: tb/sim_deadline_timer.sv
module sim_deadline_timer;
  localparam int CLK_P = 10;
  localparam int NV    = 28;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [63:0] cnt;
    logic [63:0] data;   // write data, or expected read data
    logic        irq;
    logic [7:0]  req;
  } vec_t;

  // addr: 0 ctl, 1 cmp, 2 rel, 3 count
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 64'd100,  64'd0,    1'b0, 8'd1},  // R1 ctl zero
    '{1'b0, 2'd1, 64'd100,  64'd0,    1'b0, 8'd1},  // R1 cmp zero
    '{1'b1, 2'd1, 64'd100,  64'd1000, 1'b0, 8'd5},  // R5 set future deadline
    '{1'b1, 2'd0, 64'd100,  64'd1,    1'b0, 8'd4},  // R4 enabled, far off
    '{1'b0, 2'd0, 64'd999,  64'd1,    1'b0, 8'd3},  // R3 one tick early
    '{1'b0, 2'd0, 64'd1000, 64'd5,    1'b1, 8'd3},  // R3 exactly at deadline
    '{1'b0, 2'd0, 64'd1001, 64'd5,    1'b1, 8'd4},  // R4 level held
    '{1'b0, 2'd0, 64'd500,  64'd1,    1'b0, 8'd4},  // R4 follows count back
    '{1'b1, 2'd1, 64'd500,  64'd400,  1'b1, 8'd5},  // R5 past deadline fires
    '{1'b1, 2'd0, 64'd500,  64'd3,    1'b0, 8'd10}, // R10 mask
    '{1'b0, 2'd0, 64'd500,  64'd7,    1'b0, 8'd10}, // R10 status visible
    '{1'b1, 2'd0, 64'd500,  64'd1,    1'b1, 8'd4},  // R4 unmask
    '{1'b1, 2'd0, 64'd500,  64'd0,    1'b0, 8'd6},  // R6 ctl cleared
    '{1'b0, 2'd0, 64'd500,  64'd0,    1'b0, 8'd3},  // R3 status 0 when off
    '{1'b1, 2'd0, 64'd500,  64'hFFFF_FFFF_FFFF_FFFD, 1'b1, 8'd2}, // R2 upper bits dropped
    '{1'b0, 2'd0, 64'd500,  64'd5,    1'b1, 8'd2},  // R2 layout
    '{1'b1, 2'd2, 64'd2000, 64'd10,   1'b0, 8'd7},  // R7 positive offset
    '{1'b0, 2'd1, 64'd2000, 64'd2010, 1'b0, 8'd7},  // R7 cmp result
    '{1'b0, 2'd2, 64'd2004, 64'd6,    1'b0, 8'd8},  // R8 ticks left
    '{1'b0, 2'd2, 64'd2013, 64'hFFFF_FFFF_FFFF_FFFD, 1'b1, 8'd8}, // R8 negative after expiry
    '{1'b1, 2'd2, 64'd5000, 64'h0000_0000_FFFF_FFF6, 1'b1, 8'd7}, // R7 negative offset
    '{1'b0, 2'd1, 64'd5000, 64'd4990, 1'b1, 8'd7},  // R7 sign extended
    '{1'b0, 2'd3, 64'h1_2345_6789, 64'h1_2345_6789, 1'b1, 8'd9}, // R9 count read
    '{1'b1, 2'd3, 64'd4000, 64'd7,    1'b0, 8'd9},  // R9 count write
    '{1'b0, 2'd1, 64'd4000, 64'd4990, 1'b0, 8'd9},  // R9 cmp untouched
    '{1'b1, 2'd1, 64'h7FFF_FFFF_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 8'd3}, // R3 high deadline
    '{1'b0, 2'd2, 64'h7FFF_FFFF_0000_0010, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 8'd8}, // R8 truncated view
    '{1'b0, 2'd0, 64'h8000_0000_0000_0000, 64'd5, 1'b1, 8'd3}  // R3 unsigned crossing
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        irq;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  deadline_timer u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .count_i (count),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1 chk("R1 irq in reset", {63'd0, irq}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      count = VEC[i].cnt;
      addr  = VEC[i].addr;
      wdata = VEC[i].data;
      wr_en = VEC[i].wr;
      if (VEC[i].wr) begin
        @(posedge clk);
        #1 wr_en = 1'b0;
        #1 chk($sformatf("R%0d vec %0d irq", VEC[i].req, i), {63'd0, irq}, {63'd0, VEC[i].irq});
      end else begin
        #1;
        chk($sformatf("R%0d vec %0d rdata", VEC[i].req, i), rdata, VEC[i].data);
        chk($sformatf("R%0d vec %0d irq", VEC[i].req, i), {63'd0, irq}, {63'd0, VEC[i].irq});
      end
    end

    // R1: reset while firing
    count = 64'd50;
    wr(2'd1, 64'd10);
    wr(2'd0, 64'd1);
    #1 chk("R1 pre-reset irq", {63'd0, irq}, 64'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 irq under reset", {63'd0, irq}, 64'd0);
    addr = 2'd0;
    #1 chk("R1 ctl under reset", rdata, 64'd0);
    addr = 2'd1;
    #1 chk("R1 cmp under reset", rdata, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 irq after reset", {63'd0, irq}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule